// File: doc/BRIEF.md
# Serial Boot Loader Protocol Sequencer

This block drives the byte-level conversation between a host and the on-chip boot logic once the serial bit rate has been locked. It receives bytes from the UART one at a time and sends bytes back through a single transmit holding slot. It confirms the link with a fixed request/answer pair of bytes, then takes a two-byte program length with the high byte first. After that it loads the given number of program bytes into on-chip RAM, echoing every byte it accepts back to the host.

When the last program byte has been echoed, the block hands over to an external flash controller. That controller checks whether the flash holds data and erases every block if it does. The block then reports the outcome to the host. On success it raises a start signal so the processor can run the program now held in RAM. On failure it stops for good in an abort state. The UART and the flash controller are outside the block.

Top module: `bootseq_top`

## Requirements
- R1: After reset, tx_valid, ram_we, erase_req and start_exec are low, and the block sends nothing in reply to received bytes until lock_sent has been high for at least one clock edge.
- R2: While waiting for confirmation, a received 0x55 is answered with one transmitted 0xAA. Any other byte value produces no transmission, and the block keeps waiting.
- R3: The two bytes after the confirmation form the length N (first byte = N[15:8], second byte = N[7:0]). Each of the two is echoed unchanged.
- R4: Each of the N program bytes is echoed unchanged. In the cycle it is accepted, ram_we is high, ram_wdata equals the byte, and ram_addr equals its index (0 for the first byte, incremented by one per byte).
- R5: Once tx_valid is high, it stays high and tx_data stays stable until a cycle with tx_ready high. A byte received while an echo is still pending is dropped: it causes no RAM write and no echo.
- R6: A length of zero skips the load phase. erase_req rises with no RAM write.
- R7: erase_req rises only after the final echo of the load phase has been accepted, and it stays high until erase_done.
- R8: erase_done with erase_fail low makes the block send 0xAA. start_exec rises in the cycle after that report is accepted and then stays high.
- R9: erase_done with erase_fail high makes the block send 0xFF and enter a terminal abort state. After that, start_exec and erase_req stay low and every received byte is ignored.
- R10: Reset clears the byte counter and the RAM address, so the next load starts again at address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lock_sent | input | 1 | The bit-rate lock marker has gone out to the host |
| rx_valid | input | 1 | One-cycle strobe: rx_data holds a received byte |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Transmit slot holds a byte for the UART |
| tx_ready | input | 1 | UART accepts the byte offered this cycle |
| tx_data | output | 8 | Byte to transmit |
| ram_we | output | 1 | Write strobe for the on-chip RAM |
| ram_addr | output | ADDR_W | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| erase_req | output | 1 | Request to the flash controller to check and erase |
| erase_done | input | 1 | Flash controller has finished the request |
| erase_fail | input | 1 | Qualifies erase_done: the erase failed |
| start_exec | output | 1 | Start running the program loaded into RAM |

## Verification
The assertions assume that the flash controller raises erase_done only while erase_req is high, and that the host sends a new byte only after the previous echo has been accepted, except where R5 deliberately breaks this rule. The stimulus respects both assumptions. Erase completion is driven only after the bench has seen erase_req. Each byte is sent only after the bench has completed the echo handshake with a random number of tx_ready stall cycles, with a single injected byte inside a stall that exercises the drop rule. Payload lengths and values come from $urandom with a fixed seed. Directed sessions cover the zero-length case, a failed erase, and a run after an abort.

// File: rtl/bootseq_pkg.sv
// Package: shared constants and the state type of the boot protocol sequencer.
// Assumes 8-bit bytes on every byte-level interface.
package bootseq_pkg;
    localparam int BYTE_W = 8;
    localparam int LEN_W  = 2 * BYTE_W;

    localparam logic [BYTE_W-1:0] CONF_REQ = 8'h55;
    localparam logic [BYTE_W-1:0] CONF_ACK = 8'hAA;
    localparam logic [BYTE_W-1:0] RES_OK   = 8'hAA;
    localparam logic [BYTE_W-1:0] RES_FAIL = 8'hFF;

    typedef enum logic [3:0] {
        ST_LOCK,
        ST_CONF,
        ST_LEN_HI,
        ST_LEN_LO,
        ST_LOAD,
        ST_ERASE,
        ST_REPORT,
        ST_RUN,
        ST_ABORT
    } seq_state_t;
endpackage

// File: rtl/bootseq_tx_slot.sv
// Module: single-entry transmit holding register with a valid/ready output.
// Assumes push is raised only while the slot is empty.
module bootseq_tx_slot
    import bootseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [BYTE_W-1:0] push_byte,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    output logic              fire
);
    assign fire = tx_valid && tx_ready;

    // Fill the slot on push; empty it when the UART takes the byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else if (push) begin
            tx_valid <= 1'b1;
            tx_data  <= push_byte;
        end else if (fire) begin
            tx_valid <= 1'b0;
        end
    end

    // A pending byte holds still until the UART takes it.
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // Never overwrite a byte that is still pending.
    p_no_overwrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !tx_valid);
endmodule

// File: rtl/bootseq_load_ctr.sv
// Module: length register, remaining-byte counter and RAM write address.
// Assumes ld_hi, ld_lo and step are mutually exclusive one-cycle strobes.
module bootseq_load_ctr
    import bootseq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_hi,
    input  logic              ld_lo,
    input  logic              step,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              len_is_zero,
    output logic              last_byte,
    output logic [ADDR_W-1:0] addr
);
    logic [BYTE_W-1:0] hi_q;
    logic [LEN_W-1:0]  remain_q;

    assign len_is_zero = ({hi_q, in_byte} == '0);
    assign last_byte   = (remain_q == LEN_W'(1));

    // Capture the length bytes, then count bytes down and the address up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q     <= '0;
            remain_q <= '0;
            addr     <= '0;
        end else if (ld_hi) begin
            hi_q <= in_byte;
        end else if (ld_lo) begin
            remain_q <= {hi_q, in_byte};
            addr     <= '0;
        end else if (step) begin
            remain_q <= remain_q - LEN_W'(1);
            addr     <= addr + ADDR_W'(1);
        end
    end

    // Each accepted program byte moves the address on by one.
    p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (addr == $past(addr) + ADDR_W'(1)));

    // The counter is never stepped once it is exhausted.
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (remain_q != '0));
endmodule

// File: rtl/bootseq_ctrl.sv
// Module: protocol state machine. It accepts a received byte only while the
// transmit slot is empty, and gates the erase request on an empty slot.
// Assumes erase_done is raised only while erase_req is high.
module bootseq_ctrl
    import bootseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_sent,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              slot_busy,
    input  logic              tx_fire,
    input  logic              len_is_zero,
    input  logic              last_byte,
    input  logic              erase_done,
    input  logic              erase_fail,
    output logic              push,
    output logic [BYTE_W-1:0] push_byte,
    output logic              ld_hi,
    output logic              ld_lo,
    output logic              step,
    output logic              ram_we,
    output logic              erase_req,
    output logic              start_exec
);
    seq_state_t state_q, state_d;
    logic       take;

    assign take = rx_valid && !slot_busy;

    // Next state and the one-cycle strobes for each state.
    always_comb begin
        state_d    = state_q;
        push       = 1'b0;
        push_byte  = rx_data;
        ld_hi      = 1'b0;
        ld_lo      = 1'b0;
        step       = 1'b0;
        ram_we     = 1'b0;
        erase_req  = 1'b0;
        start_exec = 1'b0;
        case (state_q)
            ST_LOCK: begin
                if (lock_sent) state_d = ST_CONF;
            end
            ST_CONF: begin
                if (take && rx_data == CONF_REQ) begin
                    push      = 1'b1;
                    push_byte = CONF_ACK;
                    state_d   = ST_LEN_HI;
                end
            end
            ST_LEN_HI: begin
                if (take) begin
                    push    = 1'b1;
                    ld_hi   = 1'b1;
                    state_d = ST_LEN_LO;
                end
            end
            ST_LEN_LO: begin
                if (take) begin
                    push    = 1'b1;
                    ld_lo   = 1'b1;
                    state_d = len_is_zero ? ST_ERASE : ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (take) begin
                    push    = 1'b1;
                    step    = 1'b1;
                    ram_we  = 1'b1;
                    state_d = last_byte ? ST_ERASE : ST_LOAD;
                end
            end
            ST_ERASE: begin
                erase_req = !slot_busy;
                if (!slot_busy && erase_done) begin
                    push      = 1'b1;
                    push_byte = erase_fail ? RES_FAIL : RES_OK;
                    state_d   = erase_fail ? ST_ABORT : ST_REPORT;
                end
            end
            ST_REPORT: begin
                if (tx_fire) state_d = ST_RUN;
            end
            ST_RUN: begin
                start_exec = 1'b1;
            end
            ST_ABORT: begin
                state_d = ST_ABORT;
            end
            default: state_d = ST_LOCK;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOCK;
        else        state_q <= state_d;
    end

    // The request stays up until the flash controller answers.
    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && !erase_done) |=> erase_req);

    // The start signal never drops once raised.
    p_start_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_exec |=> start_exec);

    // The abort state is terminal and silent.
    p_abort_final_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ABORT) |=> (state_q == ST_ABORT && !push && !erase_req));

    // No RAM write while an echo is still pending.
    p_drop_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> !slot_busy);
endmodule

// File: rtl/bootseq_top.sv
// Module: top of the serial boot loader protocol sequencer. It wires the
// controller, the transmit slot and the load counter together.
// Assumes a byte-level UART (single-cycle rx strobe) and an external flash
// controller that checks and erases on request.
module bootseq_top
    import bootseq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_sent,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [7:0]        ram_wdata,
    output logic              erase_req,
    input  logic              erase_done,
    input  logic              erase_fail,
    output logic              start_exec
);
    logic              push, fire, ld_hi, ld_lo, step;
    logic              len_is_zero, last_byte;
    logic [BYTE_W-1:0] push_byte;

    assign ram_wdata = rx_data;

    bootseq_ctrl ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .lock_sent   (lock_sent),
        .rx_valid    (rx_valid),
        .rx_data     (rx_data),
        .slot_busy   (tx_valid),
        .tx_fire     (fire),
        .len_is_zero (len_is_zero),
        .last_byte   (last_byte),
        .erase_done  (erase_done),
        .erase_fail  (erase_fail),
        .push        (push),
        .push_byte   (push_byte),
        .ld_hi       (ld_hi),
        .ld_lo       (ld_lo),
        .step        (step),
        .ram_we      (ram_we),
        .erase_req   (erase_req),
        .start_exec  (start_exec)
    );

    bootseq_tx_slot slot_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_byte (push_byte),
        .tx_ready  (tx_ready),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .fire      (fire)
    );

    bootseq_load_ctr #(.ADDR_W(ADDR_W)) ctr_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ld_hi       (ld_hi),
        .ld_lo       (ld_lo),
        .step        (step),
        .in_byte     (rx_data),
        .len_is_zero (len_is_zero),
        .last_byte   (last_byte),
        .addr        (ram_addr)
    );

    // The erase step and program start never overlap.
    p_start_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_exec |-> (!erase_req && !ram_we));
endmodule

// File: tb/bootseq_top_tb_top.sv
module bootseq_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lock_sent = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [7:0]  tx_data;
    logic        ram_we;
    logic [15:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic        erase_req;
    logic        erase_done = 1'b0;
    logic        erase_fail = 1'b0;
    logic        start_exec;

    int n_checks = 0;
    int n_fails  = 0;
    int sess     = 0;

    always #2 clk = ~clk;

    bootseq_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .lock_sent  (lock_sent),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .tx_valid   (tx_valid),
        .tx_ready   (tx_ready),
        .tx_data    (tx_data),
        .ram_we     (ram_we),
        .ram_addr   (ram_addr),
        .ram_wdata  (ram_wdata),
        .erase_req  (erase_req),
        .erase_done (erase_done),
        .erase_fail (erase_fail),
        .start_exec (start_exec)
    );

    function automatic logic [7:0] report_byte(bit fail);
        return fail ? 8'hFF : 8'hAA;
    endfunction

    function automatic logic [7:0] noise_byte();
        logic [7:0] b;
        b = 8'($urandom);
        if (b == 8'h55) b = 8'h54;
        return b;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic send_rx(logic [7:0] b, bit exp_we, int exp_addr, string req);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = b;
        #1;
        chk(ram_we == exp_we, req, "ram_we", int'(ram_we), int'(exp_we));
        if (exp_we) begin
            chk(int'(ram_addr) == exp_addr, req, "ram_addr", int'(ram_addr), exp_addr);
            chk(ram_wdata == b, req, "ram_wdata", int'(ram_wdata), int'(b));
        end
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic expect_tx(logic [7:0] exp, string req, bit inject);
        int waited = 0;
        logic [7:0] first;
        while (!tx_valid && waited < 20) begin
            @(negedge clk);
            waited++;
        end
        chk(tx_valid, req, "tx_valid", int'(tx_valid), 1);
        chk(!erase_req, "R7", "erase_req during echo", int'(erase_req), 0);
        chk(!start_exec, "R8", "start_exec before report", int'(start_exec), 0);
        first = tx_data;
        if (inject) begin
            rx_valid = 1'b1;
            rx_data  = ~first;
            #1;
            chk(!ram_we, "R5", "ram_we on byte during echo", int'(ram_we), 0);
            @(negedge clk);
            rx_valid = 1'b0;
        end
        for (int k = 0; k < int'($urandom % 4); k++) begin
            @(negedge clk);
            chk(tx_valid && tx_data == first, "R5", "tx held", int'(tx_data), int'(first));
        end
        chk(tx_data == exp, req, "tx_data", int'(tx_data), int'(exp));
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
        chk(!tx_valid, req, "tx_valid after accept", int'(tx_valid), 0);
    endtask

    task automatic expect_silence(string req);
        repeat (6) @(negedge clk);
        chk(!tx_valid, req, "no transmit", int'(tx_valid), 0);
    endtask

    task automatic run_session(int n, bit fail);
        logic [7:0] b;
        int wait_n;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!tx_valid && !ram_we && !erase_req && !start_exec, "R1", "reset outputs",
            int'({tx_valid, ram_we, erase_req, start_exec}), 0);
        // Bytes before the lock marker get no answer.
        send_rx(8'h55, 1'b0, 0, "R1");
        expect_silence("R1");
        lock_sent = 1'b1;
        @(negedge clk);
        lock_sent = 1'b0;
        // Wrong confirmation value is ignored.
        send_rx(noise_byte(), 1'b0, 0, "R2");
        expect_silence("R2");
        send_rx(8'h55, 1'b0, 0, "R2");
        expect_tx(8'hAA, "R2", 1'b0);
        send_rx(8'(n >> 8), 1'b0, 0, "R3");
        expect_tx(8'(n >> 8), "R3", 1'b0);
        send_rx(8'(n), 1'b0, 0, "R3");
        expect_tx(8'(n), "R3", 1'b0);
        for (int i = 0; i < n; i++) begin
            b = 8'($urandom);
            send_rx(b, 1'b1, i, (i == 0 && sess > 0) ? "R10" : "R4");
            expect_tx(b, "R4", i == 1);
        end
        wait_n = 0;
        while (!erase_req && wait_n < 20) begin
            @(negedge clk);
            wait_n++;
        end
        chk(erase_req, (n == 0) ? "R6" : "R7", "erase_req raised", int'(erase_req), 1);
        repeat (1 + int'($urandom % 5)) begin
            @(negedge clk);
            chk(erase_req, "R7", "erase_req held", int'(erase_req), 1);
        end
        erase_done = 1'b1;
        erase_fail = fail;
        @(negedge clk);
        erase_done = 1'b0;
        erase_fail = 1'b0;
        expect_tx(report_byte(fail), fail ? "R9" : "R8", 1'b0);
        if (!fail) begin
            chk(start_exec, "R8", "start_exec after report", int'(start_exec), 1);
            repeat (3) @(negedge clk);
            chk(start_exec, "R8", "start_exec held", int'(start_exec), 1);
        end else begin
            send_rx(8'h55, 1'b0, 0, "R9");
            expect_silence("R9");
            chk(!start_exec && !erase_req, "R9", "abort quiet",
                int'({start_exec, erase_req}), 0);
        end
        sess++;
    endtask

    initial begin
        int seed_v;
        seed_v = int'($urandom(32'h0000B00D));
        run_session(5, 1'b0);
        run_session(0, 1'b0);
        for (int s = 0; s < 3; s++) run_session(1 + int'($urandom % 24), 1'b0);
        run_session(4, 1'b1);
        run_session(3, 1'b0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule